// File: doc/BRIEF.md
# Auxiliary Timestamp Snapshot Unit

This block records the moment at which external events happen, measured against a precision-time clock. Up to four trigger lines come in from outside the clock domain's logic. Each line can be enabled on its own. When an enabled line goes from low to high, the block stores the current seconds and nanoseconds value in a sixteen-entry FIFO. It also raises an event flag and an interrupt.

The time value itself is an input, driven by a time counter elsewhere. Software reaches the unit through a simple 32-bit register bus:

- The control word enables triggers and flushes the FIFO.
- Two data words hold the oldest snapshot. Reading the seconds word removes that snapshot from the FIFO.
- A status word packs the occupancy count, the event flag and an overflow flag.
- An interrupt-status word holds the capture interrupt.
- A feature word reports how many trigger inputs the unit has.

To read one snapshot, software reads the nanoseconds word first and the seconds word second, so that both halves belong to the same capture. It can poll the interrupt bit to learn that a capture has happened.

Top module: `aux_tsnap_unit`

## Requirements
- R1: After reset, every register reads zero except the feature word. This includes the control word, the status word, the interrupt-status word and both data words. The irq pin is low.
- R2: An enabled trigger that rises adds exactly one snapshot. A trigger whose enable bit is 0 adds nothing, and the status count stays unchanged. Enables are control word (offset 0x040) bits 7:4, with bit 4+i for input i.
- R3: A trigger that stays high, or that falls, adds no further snapshot.
- R4: The nanoseconds word (offset 0x048, bits 29:0) and the seconds word (offset 0x04C) always show the oldest held snapshot. Reading the nanoseconds word removes nothing. Reading the seconds word removes that snapshot. Snapshots leave in capture order. Both words read zero when the FIFO is empty.
- R5: When several enabled triggers rise in the same cycle, they are stored one per cycle with the lowest-numbered input first. Each one gets the time at its own storing cycle.
- R6: The FIFO holds 16 snapshots. A capture that arrives while it is full is dropped and sets the sticky overflow flag, status bit 3.
- R7: Writing 1 to control bit 0 empties the FIFO. Bit 0 reads back 1 in the cycle after the write and 0 after that. The enable bits keep the value written with it.
- R8: The status word (offset 0xB20) holds the count in bits 29:25, the event flag in bit 2 and overflow in bit 3. Reading it clears the event flag, the overflow flag and the interrupt.
- R9: Each stored snapshot sets interrupt-status bit 12 (offset 0x0B0), sets the event flag, and drives irq high.
- R10: Feature word (offset 0x124) bits 30:28 give the number of trigger inputs.
- R11: A nanoseconds value read back never exceeds 999,999,999, given a time input that respects the rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_in | input | N_IN | Asynchronous trigger lines |
| time_sec | input | 32 | Current seconds of the time counter |
| time_ns | input | 30 | Current nanoseconds of the time counter |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Capture interrupt |

## Verification
A trigger change driven just after a falling edge is stored on the third rising edge that follows. The stored time is the one presented at that edge. Each further simultaneous trigger is stored one edge later. Read data is combinational, so the bench samples it a little after the falling edge on which it drives the access. Pops, flag clears and flush writes take effect at the next rising edge, and the flush empties the FIFO one edge after that. The bench therefore advances time in whole falling-edge ticks. It predicts every stored time by counting ticks to the capture edge, and it reads status only after the capture edge has passed.

// File: rtl/tsnap_pkg.sv
package tsnap_pkg;
  localparam int SEC_W = 32;
  localparam int NS_W  = 30;
  localparam logic [NS_W-1:0] NS_MAX = 30'd999_999_999;

  localparam logic [11:0] ADDR_CTRL = 12'h040;
  localparam logic [11:0] ADDR_NS   = 12'h048;
  localparam logic [11:0] ADDR_SEC  = 12'h04C;
  localparam logic [11:0] ADDR_INT  = 12'h0B0;
  localparam logic [11:0] ADDR_FEAT = 12'h124;
  localparam logic [11:0] ADDR_STAT = 12'hB20;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_EN_LSB    = 4;
  localparam int STAT_EVT_BIT   = 2;
  localparam int STAT_OVF_BIT   = 3;
  localparam int STAT_CNT_LSB   = 25;
  localparam int INT_TS_BIT     = 12;
  localparam int FEAT_NIN_LSB   = 28;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tstamp_t;
endpackage

// File: rtl/tsnap_trig_detect.sv
module tsnap_trig_detect #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] trig_in,
  input  logic [N_IN-1:0] en,
  input  logic            flush,
  output logic [N_IN-1:0] grant,
  output logic            fire
);
  logic [N_IN-1:0] s1_q, s2_q, s3_q, pend_q;
  logic [N_IN-1:0] rise, req, pend_d;

  always_comb begin
    rise   = s2_q & ~s3_q;
    req    = pend_q | (rise & en);
    grant  = req & (~req + 1'b1);
    fire   = |req;
    pend_d = flush ? '0 : (req & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= trig_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r5_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |-> fire);
endmodule

// File: rtl/tsnap_fifo.sv
module tsnap_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 62,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push & ~full & ~clr;
    do_pop  = pop & ~empty & ~clr;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
    dout  = mem[rd_q];
    count = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/aux_tsnap_unit.sv
module aux_tsnap_unit
  import tsnap_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  trig_in,
  input  logic [SEC_W-1:0] time_sec,
  input  logic [NS_W-1:0]  time_ns,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [N_IN-1:0] en_q, en_d, grant;
  logic            flush_q, flush_d, evt_q, evt_d, ovf_q, ovf_d, irq_q, irq_d;
  logic            fire, push, cap_ok, cap_drop, full, empty;
  logic            wr_ctrl, rd_stat, rd_sec, rd_ns;
  logic [CW-1:0]   cnt;
  tstamp_t         head, now_ts;
  logic [31:0]     rd_mux;
  logic            unused_bus;

  assign unused_bus = ^{bus_wdata, grant};

  tsnap_trig_detect #(.N_IN(N_IN)) u_detect (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .en(en_q),
    .flush(flush_q), .grant(grant), .fire(fire)
  );

  always_comb begin
    now_ts.sec = time_sec;
    now_ts.ns  = time_ns;
    push       = fire & ~flush_q;
    cap_ok     = push & ~full;
    cap_drop   = push & full;
    wr_ctrl    = bus_sel & bus_we & (bus_addr == ADDR_CTRL);
    rd_stat    = bus_sel & ~bus_we & (bus_addr == ADDR_STAT);
    rd_sec     = bus_sel & ~bus_we & (bus_addr == ADDR_SEC);
    rd_ns      = bus_sel & ~bus_we & (bus_addr == ADDR_NS);
  end

  tsnap_fifo #(.DEPTH(DEPTH), .W($bits(tstamp_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(flush_q), .push(push), .pop(rd_sec),
    .din(now_ts), .dout(head), .count(cnt), .full(full), .empty(empty)
  );

  always_comb begin
    en_d    = en_q;
    flush_d = 1'b0;
    evt_d   = evt_q;
    ovf_d   = ovf_q;
    irq_d   = irq_q;
    if (wr_ctrl) begin
      en_d    = bus_wdata[CTRL_EN_LSB +: N_IN];
      flush_d = bus_wdata[CTRL_FLUSH_BIT];
    end
    if (rd_stat) begin
      evt_d = 1'b0;
      ovf_d = 1'b0;
      irq_d = 1'b0;
    end
    if (cap_ok) begin
      evt_d = 1'b1;
      irq_d = 1'b1;
    end
    if (cap_drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      flush_q <= 1'b0;
      evt_q   <= 1'b0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      flush_q <= flush_d;
      evt_q   <= evt_d;
      ovf_q   <= ovf_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        rd_mux[CTRL_EN_LSB +: N_IN] = en_q;
        rd_mux[CTRL_FLUSH_BIT]      = flush_q;
      end
      ADDR_NS:   if (!empty) rd_mux[NS_W-1:0] = head.ns;
      ADDR_SEC:  if (!empty) rd_mux[SEC_W-1:0] = head.sec;
      ADDR_STAT: begin
        rd_mux[STAT_CNT_LSB +: 5] = 5'(cnt);
        rd_mux[STAT_OVF_BIT]      = ovf_q;
        rd_mux[STAT_EVT_BIT]      = evt_q;
      end
      ADDR_INT:  rd_mux[INT_TS_BIT] = irq_q;
      ADDR_FEAT: rd_mux[FEAT_NIN_LSB +: 3] = 3'(N_IN);
      default:   rd_mux = '0;
    endcase
    bus_rdata = (bus_sel && !bus_we) ? rd_mux : '0;
    irq       = irq_q;
  end

  a_r9_irq_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok |=> (irq && evt_q));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !push) |=> (!irq && !evt_q && !ovf_q));
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cap_drop |=> ovf_q);
  a_r11_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ns |-> (bus_rdata <= 32'(NS_MAX)));
  a_r7_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (cnt == '0));
endmodule

// File: tb/aux_tsnap_unit_bench.sv
`timescale 1ns/1ps
module aux_tsnap_unit_bench;
  localparam logic [11:0] A_CTRL = 12'h040, A_NS = 12'h048, A_SEC = 12'h04C;
  localparam logic [11:0] A_INT = 12'h0B0, A_FEAT = 12'h124, A_STAT = 12'hB20;
  localparam logic [29:0] NSMAX = 30'd999_999_999;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  trig;
  logic [31:0] tsec;
  logic [29:0] tns;
  logic        sel, we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [61:0] mq [0:255];
  int qh = 0, qt = 0;
  logic [3:0] en_m = '0;
  logic evt_m = 0, ovf_m = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  aux_tsnap_unit u_aux_tsnap_unit (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .time_sec(tsec), .time_ns(tns),
    .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [61:0] tadd(int n);
    logic [31:0] s = tsec;
    logic [29:0] ns = tns;
    for (int k = 0; k < n; k++) begin
      if (ns == NSMAX) begin ns = '0; s = s + 1; end
      else ns = ns + 1;
    end
    return {s, ns};
  endfunction

  function automatic logic [31:0] stat_word();
    return (32'(qt - qh) << 25) | (32'(ovf_m) << 3) | (32'(evt_m) << 2);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    sel = 1'b0;
    we  = 1'b0;
    if (tns == NSMAX) begin tns = '0; tsec = tsec + 1; end
    else tns = tns + 1;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    adv();
    sel = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    adv();
    sel = 1'b1; we = 1'b1; addr = a; wdata = v;
  endtask

  task automatic set_en(logic [3:0] m);
    wr(A_CTRL, {24'h0, m, 4'h0});
    en_m = m;
  endtask

  task automatic stat_chk(string tag);
    logic [31:0] v;
    rd(A_STAT, v);
    chk(tag, v, stat_word());
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, evt_m});
    evt_m = 0;
    ovf_m = 0;
  endtask

  task automatic pulse(logic [3:0] m);
    int k = 0;
    adv();
    trig = m;
    for (int i = 0; i < 4; i++) begin
      if (m[i] && en_m[i]) begin
        if (qt - qh < 16) begin
          mq[qt] = tadd(2 + k); qt++; evt_m = 1;
        end else ovf_m = 1;
        k++;
      end
    end
    repeat (4) adv();
    trig = '0;
    repeat (4) adv();
  endtask

  task automatic drain(string tag);
    logic [31:0] v;
    while (qh < qt) begin
      rd(A_NS, v);
      chk({tag, " ns"}, v, {2'b0, mq[qh][29:0]});
      checks++;
      if (v > 32'(NSMAX)) begin
        fails++;
        $display("FAIL R11 actual=%0d expected<=%0d", v, NSMAX);
      end
      rd(A_SEC, v);
      chk({tag, " sec"}, v, mq[qh][61:30]);
      qh++;
    end
    qh = 0; qt = 0;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rst_n = 0; trig = '0; sel = 0; we = 0; addr = '0; wdata = '0;
    tsec = 32'd5; tns = NSMAX - 30'd40;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_INT, v);  chk("R1 intstat", v, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_NS, v);   chk("R1 ns empty", v, 32'h0);
    rd(A_SEC, v);  chk("R1 sec empty", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    // R10 feature
    rd(A_FEAT, v); chk("R10 feature", v[30:28], 32'd4);

    // R2 disabled input ignored, enabled input captures once
    set_en(4'b0001);
    pulse(4'b0010);
    stat_chk("R2 disabled");
    pulse(4'b0001);
    chk("R9 irq pin", {31'h0, irq}, 32'h1);
    rd(A_INT, v); chk("R9 intstat bit12", v, 32'h0000_1000);
    stat_chk("R2 enabled");
    rd(A_INT, v); chk("R8 intstat cleared", v, 32'h0);

    // R3 held high and falling edge add nothing
    adv(); trig = 4'b0001; mq[qt] = tadd(2); qt++; evt_m = 1;
    repeat (12) adv();
    stat_chk("R3 held high");
    trig = '0;
    repeat (6) adv();
    stat_chk("R3 falling");

    // R4 ns read does not pop
    rd(A_NS, v); chk("R4 ns first", v, {2'b0, mq[0][29:0]});
    rd(A_NS, v); chk("R4 ns repeat", v, {2'b0, mq[0][29:0]});
    drain("R4");
    stat_chk("R4 empty after pop");

    // R5 simultaneous triggers, lowest first
    set_en(4'b1111);
    pulse(4'b1101);
    stat_chk("R5 count");
    drain("R5");

    // R6 overflow
    for (int i = 0; i < 18; i++) pulse(4'b0100);
    stat_chk("R6 full and overflow");
    stat_chk("R6 overflow cleared");
    drain("R6");

    // R7 flush
    pulse(4'b0011);
    wr(A_CTRL, 32'h0000_00F1);
    rd(A_CTRL, v); chk("R7 flush reads one", v, 32'h0000_00F1);
    qh = 0; qt = 0;
    stat_chk("R7 emptied");
    rd(A_CTRL, v); chk("R7 self clear", v, 32'h0000_00F0);
    rd(A_NS, v); chk("R7 ns empty", v, 32'h0);

    // Random rounds covering R2 R5 R6 R4
    for (int r = 0; r < 8; r++) begin
      set_en(4'($urandom_range(1, 15)));
      for (int n = 0; n < int'($urandom_range(1, 7)); n++)
        pulse(4'($urandom_range(1, 15)));
      stat_chk("R6 random status");
      drain("R4 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule